// File: doc/BRIEF.md
# Soft Mute Controller with Lock Gating

This block sits in a stereo PCM path between an input decoder and a DAC. It multiplies every sample by a gain taken from a raised-cosine table. When a mute request appears, the gain steps down through the table to zero. When the request goes away, the gain steps back up to unity. The request comes from a pin in static mode and from a register bit in control mode. The control-mode bit is kept outside the block and enters as a plain input.

A second path applies a hard mute. Three source flags are combined: PLL lock, decoder lock and PCM status. While auto-mute is enabled and any of the three flags is false, output samples are forced to zero at once, with no ramp. The same combination, registered, drives a lock indicator that downstream logic can use for muting.

Top module: `softmute_gate`

## Requirements
- R1: The mute request is `mute_pin` when `ctl_mode`=0 and `ctl_mute` when `ctl_mode`=1. The unselected input has no effect on the output.
- R2: The ramp index k moves by exactly one, toward its target, after every 32 accepted strobes spent away from the target. k never changes on a cycle without a strobe.
- R3: Gain at index k is round(16384·(1+cos(πk/32))), so k=0 gives 32768 (unity) and k=32 gives 0. A mute from unity reaches k=32 after 1024 strobes. From then on, every output sample is zero.
- R4: When the request is low, k steps down toward 0 along the same table in reverse, up to unity gain.
- R5: If the request reverses during a ramp, k turns from its current value and the hold count is not cleared. Gain never jumps by more than one table step.
- R6: Reset sets k=32 (fully muted), the hold count to 0, and `out_l`, `out_r`, `out_stb` and `lock_ind` to 0.
- R7: `lock_ind` is the AND of `pll_lock`, `dec_lock` and `pcm_flag`, registered once. A low `pcm_flag` clears it even while both locks hold.
- R8: When `auto_mute_en`=1 and that AND is false on a strobe cycle, both output samples are 0, whatever the mute request or ramp state.
- R9: When `auto_mute_en`=0, the lock flags do not affect the samples.
- R10: Output = saturate(floor((s·g + 16384) / 32768)) to 16-bit signed. At g=32768, samples pass through exactly, including -32768 and 32767.
- R11: Outputs are registered. `out_stb` is high exactly one cycle after `smp_stb`, and `out_l`/`out_r` hold their values between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | Sample strobe |
| smp_l | input | 16 | Left sample, signed |
| smp_r | input | 16 | Right sample, signed |
| mute_pin | input | 1 | Mute request in static mode |
| ctl_mute | input | 1 | Mute register bit in control mode |
| ctl_mode | input | 1 | 1 = control mode, 0 = static mode |
| auto_mute_en | input | 1 | Enables the hard mute on loss of lock |
| pll_lock | input | 1 | PLL lock flag |
| dec_lock | input | 1 | Decoder lock flag |
| pcm_flag | input | 1 | Stream carries PCM audio |
| out_l | output | 16 | Gated left sample |
| out_r | output | 16 | Gated right sample |
| out_stb | output | 1 | Output strobe, one cycle after `smp_stb` |
| lock_ind | output | 1 | Registered combined lock indicator |

## Verification
A sample offered with a strobe appears one clock later on `out_l`/`out_r` together with `out_stb`. It is scaled by the gain of the ramp index as it stood before that strobe. The index step that the strobe may cause affects only the next strobe. `lock_ind` follows the three flags one clock later on every cycle, whether or not a strobe is present. The reference model in the bench updates on the rising edge with the same one-register latency. Outputs are compared with the model on the falling edge. The directed checks count strobes exactly to land on the 32nd, 33rd, 1024th and 1025th samples of a ramp.

// File: rtl/smute_pkg.sv
package smute_pkg;

  // Raised-cosine gain in unsigned Q1.15, index 0 = unity, index steps = zero.
  function automatic int ramp_coef(input int k, input int steps);
    real ang;
    ang = 3.14159265358979323846 * real'(k) / real'(steps);
    return $rtoi($floor(16384.0 * (1.0 + $cos(ang)) + 0.5));
  endfunction

  // Signed sample times unsigned gain, rounded half-up, back to integer scale.
  function automatic int scale_round(input int s, input int g, input int frac);
    longint p;
    p = longint'(s) * longint'(g);
    p = p + (longint'(1) <<< (frac - 1));
    return int'(p >>> frac);
  endfunction

  // Clamp an integer into a signed range of the given width.
  function automatic int clamp_signed(input int v, input int w);
    int hi;
    int lo;
    hi = (1 << (w - 1)) - 1;
    lo = -(1 << (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/smute_ramp.sv
module smute_ramp #(
  parameter int STEPS = 32,
  parameter int HOLD  = 32,
  parameter int IW    = $clog2(STEPS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic          mute_req,
  output logic [IW-1:0] idx
);
  localparam int HW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [IW-1:0] IDX_TOP  = IW'(STEPS);
  localparam logic [HW-1:0] HOLD_END = HW'(HOLD - 1);

  logic [HW-1:0] hold_cnt;
  logic          at_target;
  logic          advance;

  assign at_target = mute_req ? (idx == IDX_TOP) : (idx == '0);
  assign advance   = strobe && !at_target && (hold_cnt == HOLD_END);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx      <= IDX_TOP;
      hold_cnt <= '0;
    end else if (strobe) begin
      if (at_target) begin
        hold_cnt <= '0;
      end else if (advance) begin
        hold_cnt <= '0;
        idx      <= mute_req ? idx + IW'(1) : idx - IW'(1);
      end else begin
        hold_cnt <= hold_cnt + HW'(1);
      end
    end
  end

  p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IDX_TOP);

  p_one_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (idx != $past(idx)) |-> (idx == $past(idx) + IW'(1) || idx == $past(idx) - IW'(1)));

  p_idle_no_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(strobe) |-> $stable(idx));

endmodule

// File: rtl/smute_coef_rom.sv
module smute_coef_rom #(
  parameter int STEPS = 32,
  parameter int CW    = 16,
  parameter int IW    = $clog2(STEPS + 1)
) (
  input  logic [IW-1:0] idx,
  output logic [CW-1:0] gain
);
  logic [CW-1:0] rom [0:STEPS];

  for (genvar k = 0; k <= STEPS; k++) begin : g_coef
    localparam logic [CW-1:0] COEF = CW'(smute_pkg::ramp_coef(k, STEPS));
    assign rom[k] = COEF;
  end

  assign gain = rom[idx];

endmodule

// File: rtl/smute_scale.sv
module smute_scale #(
  parameter int SW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = CW - 1
) (
  input  logic signed [SW-1:0] s_in,
  input  logic        [CW-1:0] gain,
  output logic signed [SW-1:0] s_out
);
  localparam logic [CW-1:0] UNITY = CW'(1 << FRAC);

  int rounded;

  always_comb begin
    rounded = smute_pkg::scale_round(int'(s_in), int'(gain), FRAC);
    s_out   = SW'(smute_pkg::clamp_signed(rounded, SW));
    if (gain == UNITY) begin
      p_unity_exact_r10: assert (s_out == s_in);
    end
  end

endmodule

// File: rtl/smute_lock.sv
module smute_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic pll_ok,
  input  logic dec_ok,
  input  logic pcm_ok,
  input  logic auto_en,
  output logic hard_mute,
  output logic lock_q
);
  logic lock_now;

  assign lock_now  = pll_ok && dec_ok && pcm_ok;
  assign hard_mute = auto_en && !lock_now;

  always_ff @(posedge clk) begin
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= lock_now;
  end

  p_lock_needs_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |-> ($past(pll_ok) && $past(dec_ok) && $past(pcm_ok)));

endmodule

// File: rtl/softmute_gate.sv
module softmute_gate #(
  parameter int SAMPLE_W   = 16,
  parameter int COEF_W     = 16,
  parameter int RAMP_STEPS = 32,
  parameter int STEP_HOLD  = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       smp_stb,
  input  logic signed [SAMPLE_W-1:0] smp_l,
  input  logic signed [SAMPLE_W-1:0] smp_r,
  input  logic                       mute_pin,
  input  logic                       ctl_mute,
  input  logic                       ctl_mode,
  input  logic                       auto_mute_en,
  input  logic                       pll_lock,
  input  logic                       dec_lock,
  input  logic                       pcm_flag,
  output logic signed [SAMPLE_W-1:0] out_l,
  output logic signed [SAMPLE_W-1:0] out_r,
  output logic                       out_stb,
  output logic                       lock_ind
);
  localparam int NCH   = 2;
  localparam int IDX_W = $clog2(RAMP_STEPS + 1);
  localparam logic [IDX_W-1:0] IDX_MUTED = IDX_W'(RAMP_STEPS);

  logic                       mute_req;
  logic [IDX_W-1:0]           ramp_idx;
  logic [COEF_W-1:0]          gain;
  logic                       hard_mute;
  logic signed [SAMPLE_W-1:0] ch_in     [NCH];
  logic signed [SAMPLE_W-1:0] ch_scaled [NCH];
  logic signed [SAMPLE_W-1:0] ch_q      [NCH];

  assign mute_req = ctl_mode ? ctl_mute : mute_pin;
  assign ch_in[0] = smp_l;
  assign ch_in[1] = smp_r;

  smute_ramp #(.STEPS(RAMP_STEPS), .HOLD(STEP_HOLD), .IW(IDX_W)) u_ramp (
    .clk(clk), .rst_n(rst_n), .strobe(smp_stb), .mute_req(mute_req), .idx(ramp_idx)
  );

  smute_coef_rom #(.STEPS(RAMP_STEPS), .CW(COEF_W), .IW(IDX_W)) u_rom (
    .idx(ramp_idx), .gain(gain)
  );

  smute_lock u_lock (
    .clk(clk), .rst_n(rst_n), .pll_ok(pll_lock), .dec_ok(dec_lock), .pcm_ok(pcm_flag),
    .auto_en(auto_mute_en), .hard_mute(hard_mute), .lock_q(lock_ind)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    smute_scale #(.SW(SAMPLE_W), .CW(COEF_W)) u_scale (
      .s_in(ch_in[c]), .gain(gain), .s_out(ch_scaled[c])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)       ch_q[c] <= '0;
      else if (smp_stb) ch_q[c] <= hard_mute ? '0 : ch_scaled[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_stb <= 1'b0;
    else        out_stb <= smp_stb;
  end

  assign out_l = ch_q[0];
  assign out_r = ch_q[1];

  p_stb_delay_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_stb |-> $past(smp_stb));

  p_hold_between_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(smp_stb) |-> ($stable(out_l) && $stable(out_r)));

  p_hard_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(smp_stb && auto_mute_en && !(pll_lock && dec_lock && pcm_flag))
      |-> (out_l == '0 && out_r == '0));

  p_silent_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(smp_stb && ramp_idx == IDX_MUTED) |-> (out_l == '0 && out_r == '0));

endmodule

// File: tb/tb_softmute_gate.sv
module tb_softmute_gate;
  localparam int CLK_PERIOD = 10;
  localparam int KSTEPS     = 32;
  localparam int KHOLD      = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_stb = 1'b0;
  logic signed [15:0] smp_l = '0, smp_r = '0;
  logic mute_pin = 1'b0, ctl_mute = 1'b1, ctl_mode = 1'b0, auto_mute_en = 1'b1;
  logic pll_lock = 1'b1, dec_lock = 1'b1, pcm_flag = 1'b1;
  logic signed [15:0] out_l, out_r;
  logic out_stb, lock_ind;

  softmute_gate dut (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_l(smp_l), .smp_r(smp_r),
    .mute_pin(mute_pin), .ctl_mute(ctl_mute), .ctl_mode(ctl_mode),
    .auto_mute_en(auto_mute_en), .pll_lock(pll_lock), .dec_lock(dec_lock),
    .pcm_flag(pcm_flag), .out_l(out_l), .out_r(out_r), .out_stb(out_stb),
    .lock_ind(lock_ind)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 1'b0;
  string tag      = "R6";

  // Reference model state
  int m_k = KSTEPS, m_hold = 0;
  int e_l = 0, e_r = 0, e_stb = 0, e_lock = 0;

  function automatic int ref_gain(input int k);
    return $rtoi($floor(16384.0 * (1.0 + $cos(3.14159265358979323846 * k / 32.0)) + 0.5));
  endfunction

  function automatic int ref_scale(input int s, input int g);
    longint q;
    longint r;
    q = longint'(s) * g + 16384;
    if (q >= 0) r = q / 32768;
    else        r = -((-q + 32767) / 32768);
    if (r > 32767)  r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_k = KSTEPS; m_hold = 0; e_l = 0; e_r = 0; e_stb = 0; e_lock = 0;
    end else begin
      bit req;
      bit ok;
      int tgt;
      ok     = pll_lock && dec_lock && pcm_flag;
      e_lock = ok;
      e_stb  = smp_stb;
      if (smp_stb) begin
        if (auto_mute_en && !ok) begin
          e_l = 0; e_r = 0;
        end else begin
          e_l = ref_scale(smp_l, ref_gain(m_k));
          e_r = ref_scale(smp_r, ref_gain(m_k));
        end
        req = ctl_mode ? ctl_mute : mute_pin;
        tgt = req ? KSTEPS : 0;
        if (m_k == tgt) m_hold = 0;
        else if (m_hold == KHOLD - 1) begin
          m_hold = 0;
          m_k = req ? m_k + 1 : m_k - 1;
        end else m_hold = m_hold + 1;
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(tag, "out_l model", int'(out_l), e_l);
      check(tag, "out_r model", int'(out_r), e_r);
      check(tag, "out_stb model", int'(out_stb), e_stb);
      check(tag, "lock_ind model", int'(lock_ind), e_lock);
    end
  end

  task automatic drive(input bit stb, input int l, input int r);
    smp_stb = stb;
    smp_l   = 16'(l);
    smp_r   = 16'(r);
    @(negedge clk);
  endtask

  task automatic run_random(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      drive(1'b1, $urandom_range(65535) - 32768, $urandom_range(65535) - 32768);
      for (int j = 0; j < gap; j++) drive(1'b0, 0, 0);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R6: reset state
    check("R6", "out_l in reset", int'(out_l), 0);
    check("R6", "out_stb in reset", int'(out_stb), 0);
    check("R6", "lock_ind in reset", int'(lock_ind), 0);
    rst_n = 1'b1;
    // R6: the first sample after reset is fully muted
    drive(1'b1, 1000, -1000);
    check("R6", "first sample muted", int'(out_l), 0);

    // R4: unmute ramp up to unity
    tag = "R4";
    run_random(1030, 0);
    tag = "R10";
    drive(1'b1, 12345, -32768);
    check("R10", "unity left", int'(out_l), 12345);
    check("R10", "unity right min", int'(out_r), -32768);
    drive(1'b1, 32767, -1);
    check("R10", "unity max", int'(out_l), 32767);
    check("R10", "unity -1", int'(out_r), -1);

    // R1: register bit ignored in static mode
    tag = "R1";
    ctl_mute = 1'b1;
    run_random(40, 0);
    drive(1'b1, 500, -500);
    check("R1", "ctl_mute ignored in static mode", int'(out_l), 500);

    // R2 / R3: mute ramp, exact strobe counts
    tag = "R2";
    mute_pin = 1'b1;
    for (int i = 0; i < 32; i++) drive(1'b1, 20000, 20000);
    check("R2", "32nd strobe still unity", int'(out_l), 20000);
    drive(1'b1, 20000, 20000);
    check("R2", "33rd strobe first step", int'(out_l), ref_scale(20000, ref_gain(1)));
    tag = "R3";
    for (int i = 33; i < 1023; i++) drive(1'b1, 20000, -20000);
    drive(1'b1, 20000, -20000);
    check("R3", "1024th strobe last step", int'(out_l), ref_scale(20000, ref_gain(31)));
    drive(1'b1, 20000, -20000);
    check("R3", "1025th strobe silent", int'(out_l), 0);
    check("R3", "1025th strobe silent right", int'(out_r), 0);

    // R5: reversal mid-ramp
    tag = "R5";
    mute_pin = 1'b0;
    run_random(100, 0);
    mute_pin = 1'b1;
    run_random(60, 0);
    mute_pin = 1'b0;
    run_random(45, 0);

    // R1: control mode, pin ignored
    tag = "R1";
    ctl_mode = 1'b1; ctl_mute = 1'b0; mute_pin = 1'b1;
    run_random(1100, 0);
    drive(1'b1, -7777, 7777);
    check("R1", "pin ignored in control mode", int'(out_l), -7777);

    // R11: gapped strobes, outputs held
    tag = "R11";
    ctl_mute = 1'b1;
    run_random(80, 2);
    ctl_mute = 1'b0;
    run_random(1100, 1);
    drive(1'b1, 4321, 1234);
    drive(1'b0, 0, 0);
    check("R11", "strobe low after gap", int'(out_stb), 0);
    check("R11", "value held", int'(out_l), 4321);

    // R7: lock indicator combinations
    tag = "R7";
    for (int c = 0; c < 8; c++) begin
      pll_lock = c[0]; dec_lock = c[1]; pcm_flag = c[2];
      run_random(1, 1);
    end
    pll_lock = 1'b1; dec_lock = 1'b1; pcm_flag = 1'b0;
    drive(1'b0, 0, 0);
    check("R7", "non-PCM clears lock", int'(lock_ind), 0);

    // R8: hard mute while unmuted
    tag = "R8";
    pcm_flag = 1'b1; dec_lock = 1'b0;
    drive(1'b1, 7000, -7000);
    check("R8", "hard mute zero", int'(out_l), 0);
    run_random(20, 0);

    // R9: auto-mute bypass
    tag = "R9";
    auto_mute_en = 1'b0; pll_lock = 1'b0;
    drive(1'b1, 7000, -7000);
    check("R9", "bypass passes", int'(out_l), 7000);
    run_random(20, 0);

    drive(1'b0, 0, 0);
    finish_run();
  end

endmodule